// File: doc/BRIEF.md
# USB IN Endpoint Control and Status Logic

This block holds the control and status state of one USB device IN endpoint whose FIFO can queue up to two packets. The MCU reaches it through a single-byte register port with immediate read data. The USB side supplies four simple events: an IN token has arrived, the current transmission completed successfully, a packet was loaded into the FIFO, and a level that selects isochronous mode.

For every accepted IN token the block returns one handshake decision one cycle later: send data, send a zero-length packet, answer STALL or answer NAK. Alongside it, the block shows the data toggle that goes with the response. It also tracks the number of queued packets and pulses strobes that tell the FIFO to drop its oldest packet or to throw away an arriving one. When a flush the MCU asked for has been carried out, it pulses an interrupt.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the toggle is DATA0, and `hs_valid_o`, `flush_o`, `drop_load_o` and `irq_o` are low.
- R2: Each `pkt_load_i` pulse adds one packet to the queue, up to two. Register bit 0 reads 1 while at least one packet is queued. Bit 1 reads 1 while two are queued.
- R3: An IN token with a packet queued and no stall yields `hs_kind_o` = 1 (data), shown with the current toggle. On `tx_done_i` the oldest packet leaves the queue and the toggle flips.
- R4: An IN token with an empty queue, outside isochronous mode and with no stall, yields `hs_kind_o` = 0 (NAK), and no state changes.
- R5: In isochronous mode, an IN token with an empty queue yields `hs_kind_o` = 2 (zero-length) and sets the underrun bit (bit 5). Its completion flips the toggle. The next loaded packet is discarded: `drop_load_o` pulses and the queue count does not change.
- R6: Writing 1 to bit 2 requests a flush. When no transaction is in progress, the flush is carried out the cycle after the write. `flush_o` and `irq_o` pulse, exactly one packet (the oldest) leaves the queue, and bit 2 returns to 0.
- R7: A flush requested while a transmission is in progress keeps bit 2 set and `flush_o` low until `tx_done_i`. It is carried out in the cycle after the completion.
- R8: Bit 3 is read/write and holds the send-stall control. While it is 1, an IN token yields `hs_kind_o` = 3 (STALL), sets the sent-stall bit (bit 4) and empties the queue. Writing 0 to bit 3 ends the stall.
- R9: Writing 1 to bit 7 forces the toggle to DATA0. Bit 7 always reads 0.
- R10: Bits 4, 5 and 6 are sticky. Writing 1 clears them and writing 0 leaves them unchanged. If a hardware set and a clear hit the same bit in the same cycle, the set wins.
- R11: A `pkt_load_i` while two packets are queued is ignored and sets the overflow bit (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 8 | Register write data |
| csr_rdata_o | output | 8 | Register read data |
| in_token_i | input | 1 | IN token received |
| tx_done_i | input | 1 | Current transmission completed successfully |
| pkt_load_i | input | 1 | A packet was written into the FIFO |
| iso_mode_i | input | 1 | Endpoint is isochronous |
| hs_valid_o | output | 1 | Handshake decision is valid |
| hs_kind_o | output | 2 | 0 NAK, 1 data, 2 zero-length, 3 STALL |
| toggle_o | output | 1 | Current data toggle (0 = DATA0) |
| flush_o | output | 1 | Drop the oldest queued packet |
| drop_load_o | output | 1 | Discard the packet just loaded |
| irq_o | output | 1 | Flush-complete interrupt pulse |

## Verification
Two situations are hardest to reach from the ports. The first is a deferred flush with two packets queued: it needs two loads and an accepted token, and the flush request must then land while the transmission is still open. The bench sequences exactly that, holds `tx_done_i` back for several cycles while it checks that nothing drains, and only then completes the transmission. The second is the set-versus-clear collision on the underrun bit. For that case the bench first empties the queue with a flush, then drives the isochronous token in the same cycle as the write that clears the bit.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    HS_NAK   = 2'd0,
    HS_DATA  = 2'd1,
    HS_ZLP   = 2'd2,
    HS_STALL = 2'd3
  } hs_kind_e;

  localparam int CSR_W      = 8;
  localparam int B_RDY      = 0;
  localparam int B_FULL     = 1;
  localparam int B_FLUSH    = 2;
  localparam int B_SEND_STL = 3;
  localparam int B_SENT_STL = 4;
  localparam int B_UNDERRUN = 5;
  localparam int B_OVERFLOW = 6;
  localparam int B_CLR_TOG  = 7;
endpackage

// File: rtl/usb_in_ep_hs.sv
module usb_in_ep_hs
  import usb_in_ep_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_token_i,
  input  logic          tx_done_i,
  input  logic          iso_mode_i,
  input  logic          send_stall_i,
  input  logic [CW-1:0] count_i,
  input  logic          clr_tog_i,
  output logic          hs_valid_o,
  output hs_kind_e      hs_kind_o,
  output logic          toggle_o,
  output logic          busy_o,
  output logic          data_done_o,
  output logic          stall_evt_o,
  output logic          underrun_evt_o
);
  logic busy_q, busy_data_q, toggle_q, tok;
  logic data_start, zlp_start;
  hs_kind_e kind_d;

  assign tok            = in_token_i & ~busy_q;
  assign stall_evt_o    = tok & send_stall_i;
  assign data_start     = tok & ~send_stall_i & (count_i != '0);
  assign zlp_start      = tok & ~send_stall_i & (count_i == '0) & iso_mode_i;
  assign underrun_evt_o = zlp_start;
  assign data_done_o    = tx_done_i & busy_q & busy_data_q;

  always_comb begin
    if (stall_evt_o)     kind_d = HS_STALL;
    else if (data_start) kind_d = HS_DATA;
    else if (zlp_start)  kind_d = HS_ZLP;
    else                 kind_d = HS_NAK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      busy_data_q <= 1'b0;
      toggle_q    <= 1'b0;
      hs_valid_o  <= 1'b0;
      hs_kind_o   <= HS_NAK;
    end else begin
      hs_valid_o <= tok;
      hs_kind_o  <= kind_d;
      if (data_start | zlp_start) begin
        busy_q      <= 1'b1;
        busy_data_q <= data_start;
      end else if (tx_done_i) begin
        busy_q      <= 1'b0;
        busy_data_q <= 1'b0;
      end
      // clear request overrides a completion flip
      if (clr_tog_i)                toggle_q <= 1'b0;
      else if (tx_done_i && busy_q) toggle_q <= ~toggle_q;
    end
  end

  assign toggle_o = toggle_q;
  assign busy_o   = busy_q;

  a_r5_iso_zlp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && !busy_q && iso_mode_i && !send_stall_i && count_i == '0)
      |=> (hs_valid_o && hs_kind_o == HS_ZLP));
  a_r9_tog_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tog_i |=> !toggle_o);
  a_r3_tog_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && busy_q && !clr_tog_i) |=> (toggle_o != $past(toggle_o)));
endmodule

// File: rtl/usb_in_ep_queue.sv
module usb_in_ep_queue #(
  parameter int QDEPTH = 2,
  parameter int CW     = $clog2(QDEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          data_done_i,
  input  logic          stall_evt_i,
  input  logic          underrun_evt_i,
  input  logic          flush_req_i,
  input  logic          busy_i,
  output logic [CW-1:0] count_o,
  output logic          flush_exec_o,
  output logic          overflow_evt_o,
  output logic          flush_o,
  output logic          drop_load_o
);
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic [CW-1:0] count_q;
  logic discard_q, inc, dec;

  assign flush_exec_o   = flush_req_i & ~busy_i;
  assign overflow_evt_o = load_i & ~discard_q & (count_q == FULL);
  assign inc            = load_i & ~discard_q & (count_q != FULL);
  // completion and flush are mutually exclusive via busy
  assign dec            = data_done_i | (flush_exec_o & (count_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q     <= '0;
      discard_q   <= 1'b0;
      flush_o     <= 1'b0;
      drop_load_o <= 1'b0;
    end else begin
      flush_o     <= flush_exec_o;
      drop_load_o <= load_i & discard_q;
      if (stall_evt_i)     count_q <= '0;
      else if (inc && !dec) count_q <= count_q + 1'b1;
      else if (dec && !inc) count_q <= count_q - 1'b1;
      if (underrun_evt_i)  discard_q <= 1'b1;
      else if (load_i)     discard_q <= 1'b0;
    end
  end

  assign count_o = count_q;

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL);
  a_r5_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && discard_q && !data_done_i && !flush_exec_o && !stall_evt_i)
      |=> (drop_load_o && $stable(count_q)));
endmodule

// File: rtl/usb_in_ep_status.sv
module usb_in_ep_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wr_flush_i,
  input  logic wr_send_stall_i,
  input  logic wr_clr_sent_i,
  input  logic wr_clr_under_i,
  input  logic wr_clr_ovf_i,
  input  logic flush_exec_i,
  input  logic stall_evt_i,
  input  logic underrun_evt_i,
  input  logic overflow_evt_i,
  output logic flush_req_o,
  output logic send_stall_o,
  output logic sent_stall_o,
  output logic underrun_o,
  output logic overflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_req_o  <= 1'b0;
      send_stall_o <= 1'b0;
      sent_stall_o <= 1'b0;
      underrun_o   <= 1'b0;
      overflow_o   <= 1'b0;
    end else begin
      flush_req_o <= (we_i & wr_flush_i) | (flush_req_o & ~flush_exec_i);
      if (we_i) send_stall_o <= wr_send_stall_i;
      // hardware set beats software clear
      sent_stall_o <= stall_evt_i    | (sent_stall_o & ~(we_i & wr_clr_sent_i));
      underrun_o   <= underrun_evt_i | (underrun_o   & ~(we_i & wr_clr_under_i));
      overflow_o   <= overflow_evt_i | (overflow_o   & ~(we_i & wr_clr_ovf_i));
    end
  end

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_evt_i |=> underrun_o);
  a_r10_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && we_i && !wr_clr_ovf_i) |=> overflow_o);
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  input  logic             in_token_i,
  input  logic             tx_done_i,
  input  logic             pkt_load_i,
  input  logic             iso_mode_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_kind_o,
  output logic             toggle_o,
  output logic             flush_o,
  output logic             drop_load_o,
  output logic             irq_o
);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic [CW-1:0] count;
  logic busy, data_done, stall_evt, underrun_evt, overflow_evt, flush_exec;
  logic flush_req, send_stall, sent_stall, underrun, overflow;
  logic clr_tog;
  hs_kind_e hs_kind;
  logic unused_wbits;

  assign unused_wbits = ^csr_wdata_i[B_FULL:B_RDY];
  assign clr_tog      = csr_we_i & csr_wdata_i[B_CLR_TOG];

  usb_in_ep_hs #(.CW(CW)) u_hs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_token_i    (in_token_i),
    .tx_done_i     (tx_done_i),
    .iso_mode_i    (iso_mode_i),
    .send_stall_i  (send_stall),
    .count_i       (count),
    .clr_tog_i     (clr_tog),
    .hs_valid_o    (hs_valid_o),
    .hs_kind_o     (hs_kind),
    .toggle_o      (toggle_o),
    .busy_o        (busy),
    .data_done_o   (data_done),
    .stall_evt_o   (stall_evt),
    .underrun_evt_o(underrun_evt)
  );

  usb_in_ep_queue #(.QDEPTH(QDEPTH), .CW(CW)) u_queue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (pkt_load_i),
    .data_done_i   (data_done),
    .stall_evt_i   (stall_evt),
    .underrun_evt_i(underrun_evt),
    .flush_req_i   (flush_req),
    .busy_i        (busy),
    .count_o       (count),
    .flush_exec_o  (flush_exec),
    .overflow_evt_o(overflow_evt),
    .flush_o       (flush_o),
    .drop_load_o   (drop_load_o)
  );

  usb_in_ep_status u_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (csr_we_i),
    .wr_flush_i     (csr_wdata_i[B_FLUSH]),
    .wr_send_stall_i(csr_wdata_i[B_SEND_STL]),
    .wr_clr_sent_i  (csr_wdata_i[B_SENT_STL]),
    .wr_clr_under_i (csr_wdata_i[B_UNDERRUN]),
    .wr_clr_ovf_i   (csr_wdata_i[B_OVERFLOW]),
    .flush_exec_i   (flush_exec),
    .stall_evt_i    (stall_evt),
    .underrun_evt_i (underrun_evt),
    .overflow_evt_i (overflow_evt),
    .flush_req_o    (flush_req),
    .send_stall_o   (send_stall),
    .sent_stall_o   (sent_stall),
    .underrun_o     (underrun),
    .overflow_o     (overflow)
  );

  always_comb begin
    csr_rdata_o             = '0;
    csr_rdata_o[B_RDY]      = (count != '0);
    csr_rdata_o[B_FULL]     = (count == FULL);
    csr_rdata_o[B_FLUSH]    = flush_req;
    csr_rdata_o[B_SEND_STL] = send_stall;
    csr_rdata_o[B_SENT_STL] = sent_stall;
    csr_rdata_o[B_UNDERRUN] = underrun;
    csr_rdata_o[B_OVERFLOW] = overflow;
  end

  assign hs_kind_o = hs_kind;
  assign irq_o     = flush_o;

  a_r8_stall_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_kind == HS_STALL) |-> (count == '0 && sent_stall));
  a_r6_flush_clears_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !$past(csr_we_i && csr_wdata_i[B_FLUSH])) |-> !flush_req);
  a_r11_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_evt |=> overflow);
  a_r7_no_flush_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && flush_req && !tx_done_i) |=> !flush_o);
endmodule

// File: tb/tb_usb_in_ep_ctrl.sv
module tb_usb_in_ep_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic csr_we = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata;
  logic in_token = 1'b0, tx_done = 1'b0, pkt_load = 1'b0, iso_mode = 1'b0;
  logic hs_valid, toggle, flush, drop_load, irq;
  logic [1:0] hs_kind;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic exp_tog = 1'b0;
  logic [2:0] sb[$];  // {kind, toggle}

  always #4 clk = ~clk;

  usb_in_ep_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .in_token_i(in_token), .tx_done_i(tx_done),
    .pkt_load_i(pkt_load), .iso_mode_i(iso_mode), .hs_valid_o(hs_valid),
    .hs_kind_o(hs_kind), .toggle_o(toggle), .flush_o(flush),
    .drop_load_o(drop_load), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // monitor: compare handshake responses against scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && hs_valid) begin
      if (sb.size() == 0) chk(1'b0, "R3 unexpected handshake", {hs_kind, toggle}, 0);
      else begin
        logic [2:0] e;
        e = sb.pop_front();
        chk_eq("R3/R4/R5/R8 handshake", {hs_kind, toggle}, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d; step(); csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic load();
    pkt_load = 1'b1; step(); pkt_load = 1'b0;
  endtask

  task automatic token(input logic [1:0] kind);
    sb.push_back({kind, exp_tog});
    in_token = 1'b1; step(); in_token = 1'b0;
  endtask

  task automatic done();
    tx_done = 1'b1; step(); tx_done = 1'b0;
    exp_tog = ~exp_tog;
  endtask

  initial begin
    while (cyc < 5000) @(negedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk_eq("R1 rdata", csr_rdata, 8'h00);
    chk_eq("R1 toggle", toggle, 0);
    chk_eq("R1 strobes", {hs_valid, flush, drop_load, irq}, 0);
    rst_ni = 1'b1; step();
    chk_eq("R1 rdata after release", csr_rdata, 8'h00);

    // R2 queue fill
    load(); chk_eq("R2 one queued", csr_rdata[1:0], 2'b01);
    load(); chk_eq("R2 two queued", csr_rdata[1:0], 2'b11);

    // R11 overflow
    load(); chk_eq("R11 overflow set, count kept", csr_rdata, 8'h43);

    // R10 W1C
    wr(8'h00); chk_eq("R10 zero write keeps overflow", csr_rdata[6], 1);
    wr(8'h40); chk_eq("R10 one write clears overflow", csr_rdata[6], 0);

    // R3 data + completion
    token(2'd1);
    chk_eq("R3 count during transfer", csr_rdata[1:0], 2'b11);
    done();
    chk_eq("R3 oldest removed", csr_rdata[1:0], 2'b01);
    chk_eq("R3 toggle flipped", toggle, exp_tog);

    // R6 flush with two queued
    load();
    wr(8'h04);
    chk_eq("R6 request pending", csr_rdata[2], 1);
    step();
    chk_eq("R6 flush/irq pulse", {flush, irq}, 2'b11);
    chk_eq("R6 one packet left, req cleared", csr_rdata[2:0], 3'b001);
    step();
    chk_eq("R6 pulse ends", {flush, irq}, 2'b00);

    // R7 deferred flush
    load();
    token(2'd1);
    wr(8'h04);
    for (int i = 0; i < 3; i++) begin
      chk_eq("R7 held while busy", {flush, csr_rdata[2], csr_rdata[1:0]}, 4'b0111);
      step();
    end
    done();
    chk_eq("R7 completion removes oldest", csr_rdata[1:0], 2'b01);
    chk_eq("R7 flush not yet", flush, 0);
    step();
    chk_eq("R7 flush after completion", {flush, irq}, 2'b11);
    chk_eq("R7 queue empty, req cleared", csr_rdata[2:0], 3'b000);

    // R4 NAK
    token(2'd0);
    chk_eq("R4 no state change", csr_rdata, 8'h00);
    chk_eq("R4 toggle unchanged", toggle, exp_tog);

    // R5 iso underrun
    iso_mode = 1'b1;
    token(2'd2);
    chk_eq("R5 underrun bit", csr_rdata[5], 1);
    done();
    chk_eq("R5 toggle advanced by zlp", toggle, exp_tog);
    load();
    chk_eq("R5 drop strobe", drop_load, 1);
    chk_eq("R5 count unchanged", csr_rdata[1:0], 2'b00);
    load();
    chk_eq("R5 following load kept", {drop_load, csr_rdata[1:0]}, 3'b001);

    // R10 set wins over clear
    wr(8'h04); step();
    chk_eq("R10 queue emptied", csr_rdata[1:0], 2'b00);
    sb.push_back({2'd2, exp_tog});
    in_token = 1'b1; csr_we = 1'b1; csr_wdata = 8'h20;
    step();
    in_token = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    chk_eq("R10 set beats clear", csr_rdata[5], 1);
    done();
    load();
    chk_eq("R5 discard after second underrun", {drop_load, csr_rdata[1:0]}, 3'b100);
    wr(8'h20);
    chk_eq("R10 underrun cleared", csr_rdata[5], 0);
    iso_mode = 1'b0;

    // R8 stall
    load();
    wr(8'h08);
    chk_eq("R8 send-stall reads back", csr_rdata[3], 1);
    token(2'd3);
    chk_eq("R8 sent-stall set, queue emptied", csr_rdata[4:0], 5'b11000);
    wr(8'h00);
    chk_eq("R8 stall ended, sent-stall sticky", csr_rdata[4:3], 2'b10);
    token(2'd0);
    wr(8'h10);
    chk_eq("R10 sent-stall cleared", csr_rdata, 8'h00);

    // R9 toggle clear
    load(); token(2'd1); done();
    if (!exp_tog) begin load(); token(2'd1); done(); end
    chk_eq("R9 toggle is DATA1 before clear", toggle, 1);
    wr(8'h80); exp_tog = 1'b0;
    chk_eq("R9 toggle cleared", toggle, 0);
    chk_eq("R9 bit7 reads 0", csr_rdata[7], 0);

    step(); step();
    chk_eq("R3 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule